// File: doc/BRIEF.md
# Dual 4x4 Transposing Pixel Buffer

This block holds two 4x4 blocks of 8-bit pixels in flip-flops between passes of a one-dimensional edge filter. Each bank is written one 32-bit row of four pixels per cycle. The write data comes from one of three sources: the external load path, the filter's output, or the on-chip SRAM. Both banks can be written in the same cycle, which lets one filter step refresh both blocks at once: the first-side result goes to one bank and the second-side result to the other.

Reads are combinational and return either a row or a column of a bank. Column readout lets a horizontal edge be presented to the same filter datapath that handles vertical edges. The two banks are addressed as logical bank 0 and logical bank 1. A swap control exchanges which physical bank plays each role, so the banks trade places after a filter step without any data being copied.

Top module: `tbuf_dual`

## Requirements
- R1: After reset every pixel of both banks reads as zero, and logical bank 0 maps to physical bank 0.
- R2: With wr_en_i[b]=1 and wr_tr_i=0, the selected 32-bit row is stored in row wr_idx_i of logical bank b. Byte j (bits 8j+7:8j) becomes the pixel in column j.
- R3: With rd_tr_i=0, rd0_data_o and rd1_data_o return row rd_idx_i of logical banks 0 and 1. The pixel in column j appears in byte j.
- R4: With rd_tr_i=1, the read ports return column rd_idx_i. The pixel from row r appears in byte r, so row 0 is in the least significant byte.
- R5: With wr_tr_i=1, byte r of the write data is stored in row r, column wr_idx_i. A block read transposed and written back transposed therefore keeps its orientation.
- R6: The write source is set by wr_src_i, with the same value for both banks. Value 0 selects ext_data_i. Value 1 selects the filter results: logical bank 0 takes flt0_data_i and logical bank 1 takes flt1_data_i. Value 2 selects sram_data_i. Value 3 makes no write at all.
- R7: When swap_i=1 at a clock edge, the two logical banks exchange physical banks from the next cycle on. A write in that same cycle still uses the old mapping.
- R8: A read from a bank that is being written in the same cycle returns the old contents. The new data is visible from the next cycle.
- R9: Both logical banks can be written in one cycle with independent data, and the two writes do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 2 | Write enable for each logical bank |
| wr_src_i | input | 2 | Write source: 0 ext, 1 filter, 2 SRAM, 3 none |
| wr_idx_i | input | 2 | Row index, or column index when transposed |
| wr_tr_i | input | 1 | Write column-wise |
| ext_data_i | input | 32 | External load row |
| flt0_data_i | input | 32 | Filter result for logical bank 0 |
| flt1_data_i | input | 32 | Filter result for logical bank 1 |
| sram_data_i | input | 32 | SRAM row |
| swap_i | input | 1 | Exchange the logical bank roles |
| rd_idx_i | input | 2 | Read row or column index |
| rd_tr_i | input | 1 | Read column-wise |
| rd0_data_o | output | 32 | Read data of logical bank 0 |
| rd1_data_o | output | 32 | Read data of logical bank 1 |

## Verification
The bench builds the block with its default values: 8-bit pixels and a 4x4 bank. At this size, random indices cover every row and column within a few cycles. The bench also reaches the wrap of the index fields, and swaps combined with writes and with the unused source code. Together these bring every corner of the bank mapping within reach of a few thousand cycles.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_FLT  = 2'd1,
    SRC_SRAM = 2'd2,
    SRC_NONE = 2'd3
  } wr_src_e;
endpackage

// File: rtl/tbuf_wr_mux.sv
module tbuf_wr_mux
  import tbuf_pkg::*;
#(
  parameter int ROW_W = 32
) (
  input  logic [1:0]       src_i,
  input  logic             en_i,
  input  logic [ROW_W-1:0] ext_i,
  input  logic [ROW_W-1:0] flt_i,
  input  logic [ROW_W-1:0] sram_i,
  output logic             en_o,
  output logic [ROW_W-1:0] data_o
);
  always_comb begin
    en_o   = en_i;
    data_o = ext_i;
    unique case (wr_src_e'(src_i))
      SRC_EXT:  data_o = ext_i;
      SRC_FLT:  data_o = flt_i;
      SRC_SRAM: data_o = sram_i;
      SRC_NONE: en_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/tbuf_bank.sv
module tbuf_bank #(
  parameter int PIX_W = 8,
  parameter int DIM   = 4,
  localparam int IDX_W = $clog2(DIM),
  localparam int ROW_W = DIM * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_tr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ROW_W-1:0] wr_data_i,
  input  logic             rd_tr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ROW_W-1:0] rd_data_o
);
  logic [PIX_W-1:0] pix [DIM][DIM];
  logic [DIM*ROW_W-1:0] pix_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          pix[r][c] <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < DIM; k++) begin
        if (wr_tr_i) pix[k][wr_idx_i] <= wr_data_i[k*PIX_W +: PIX_W];
        else         pix[wr_idx_i][k] <= wr_data_i[k*PIX_W +: PIX_W];
      end
    end
  end

  // Old contents on same-cycle read: read path is combinational from state
  always_comb begin
    for (int k = 0; k < DIM; k++)
      rd_data_o[k*PIX_W +: PIX_W] = rd_tr_i ? pix[k][rd_idx_i] : pix[rd_idx_i][k];
  end

  always_comb begin
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        pix_flat[(r*DIM+c)*PIX_W +: PIX_W] = pix[r][c];
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pix_flat)); // R8

  for (genvar k = 0; k < DIM; k++) begin : g_chk
    AST_ROW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_tr_i) |=> pix[$past(wr_idx_i)][k] == $past(wr_data_i[k*PIX_W +: PIX_W])); // R2
    AST_COL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_tr_i) |=> pix[k][$past(wr_idx_i)] == $past(wr_data_i[k*PIX_W +: PIX_W])); // R5
  end
endmodule

// File: rtl/tbuf_dual.sv
module tbuf_dual
  import tbuf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM   = 4,
  localparam int IDX_W = $clog2(DIM),
  localparam int ROW_W = DIM * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       wr_en_i,
  input  logic [1:0]       wr_src_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_tr_i,
  input  logic [ROW_W-1:0] ext_data_i,
  input  logic [ROW_W-1:0] flt0_data_i,
  input  logic [ROW_W-1:0] flt1_data_i,
  input  logic [ROW_W-1:0] sram_data_i,
  input  logic             swap_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_tr_i,
  output logic [ROW_W-1:0] rd0_data_o,
  output logic [ROW_W-1:0] rd1_data_o
);
  localparam int NB = 2;

  logic             role_q;  // physical bank serving logical bank 0
  logic [NB-1:0]    lg_en;
  logic [ROW_W-1:0] lg_data [NB];
  logic [ROW_W-1:0] ph_rd   [NB];
  logic [ROW_W-1:0] flt_data [NB];

  assign flt_data[0] = flt0_data_i;
  assign flt_data[1] = flt1_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     role_q <= 1'b0;
    else if (swap_i) role_q <= ~role_q;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lg
    tbuf_wr_mux #(.ROW_W(ROW_W)) u_mux (
      .src_i  (wr_src_i),
      .en_i   (wr_en_i[b]),
      .ext_i  (ext_data_i),
      .flt_i  (flt_data[b]),
      .sram_i (sram_data_i),
      .en_o   (lg_en[b]),
      .data_o (lg_data[b])
    );
  end

  for (genvar p = 0; p < NB; p++) begin : g_ph
    logic lsel;
    assign lsel = role_q ^ p[0];
    tbuf_bank #(.PIX_W(PIX_W), .DIM(DIM)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (lg_en[lsel]),
      .wr_tr_i   (wr_tr_i),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (lg_data[lsel]),
      .rd_tr_i   (rd_tr_i),
      .rd_idx_i  (rd_idx_i),
      .rd_data_o (ph_rd[p])
    );
  end

  assign rd0_data_o = ph_rd[role_q];
  assign rd1_data_o = ph_rd[~role_q];

  AST_SWAP_EXCHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && wr_en_i == '0) |=>
      (!($stable(rd_idx_i) && $stable(rd_tr_i)) || rd0_data_o == $past(rd1_data_o))); // R7
  AST_NONE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_src_i == SRC_NONE && !swap_i) |=>
      (!($stable(rd_idx_i) && $stable(rd_tr_i)) ||
       (rd0_data_o == $past(rd0_data_o) && rd1_data_o == $past(rd1_data_o)))); // R6
endmodule

// File: tb/tbuf_dual_tb.sv
module tbuf_dual_tb;
  localparam int PIX_W = 8;
  localparam int DIM   = 4;
  localparam int ROW_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] wr_en = '0, wr_src = '0, wr_idx = '0, rd_idx = '0;
  logic wr_tr = 1'b0, swap = 1'b0, rd_tr = 1'b0;
  logic [ROW_W-1:0] ext_d = '0, flt0_d = '0, flt1_d = '0, sram_d = '0;
  logic [ROW_W-1:0] rd0, rd1;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [2][DIM][DIM];
  logic mrole;

  always #2 clk = ~clk;

  tbuf_dual #(.PIX_W(PIX_W), .DIM(DIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_src_i(wr_src),
    .wr_idx_i(wr_idx), .wr_tr_i(wr_tr), .ext_data_i(ext_d),
    .flt0_data_i(flt0_d), .flt1_data_i(flt1_d), .sram_data_i(sram_d),
    .swap_i(swap), .rd_idx_i(rd_idx), .rd_tr_i(rd_tr),
    .rd0_data_o(rd0), .rd1_data_o(rd1));

  function automatic logic [ROW_W-1:0] exp_rd(input int lb, input int idx, input logic tr);
    logic [ROW_W-1:0] v;
    int p = lb ^ int'(mrole);
    for (int k = 0; k < DIM; k++)
      v[k*8 +: 8] = tr ? mdl[p][k][idx] : mdl[p][idx][k];
    return v;
  endfunction

  function automatic logic [ROW_W-1:0] src_data(input int lb);
    case (wr_src)
      2'd0: return ext_d;
      2'd1: return lb == 0 ? flt0_d : flt1_d;
      default: return sram_d;
    endcase
  endfunction

  task automatic check(input string tag, input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are already set (after negedge); check reads, then clock and update model
  task automatic step(input string tag);
    logic [ROW_W-1:0] d [2];
    #1;
    check(tag, rd0, exp_rd(0, int'(rd_idx), rd_tr));
    check(tag, rd1, exp_rd(1, int'(rd_idx), rd_tr));
    d[0] = src_data(0);
    d[1] = src_data(1);
    @(posedge clk);
    for (int b = 0; b < 2; b++) begin
      if (wr_en[b] && wr_src != 2'd3) begin
        int p = b ^ int'(mrole);
        for (int k = 0; k < DIM; k++)
          if (wr_tr) mdl[p][k][wr_idx] = d[b][k*8 +: 8];
          else       mdl[p][wr_idx][k] = d[b][k*8 +: 8];
      end
    end
    if (swap) mrole = ~mrole;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = '0; swap = 1'b0;
  endtask

  task automatic read_all(input string tag);
    idle();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DIM; i++) begin
        rd_idx = 2'(i); rd_tr = t[0];
        step(tag);
      end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mrole = 1'b0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          mdl[p][r][c] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    read_all("R1 reset zero");

    // R2/R3/R4: row writes to logical bank 0 with a known pattern
    wr_src = 2'd0; wr_tr = 1'b0;
    for (int r = 0; r < DIM; r++) begin
      wr_en = 2'b01; wr_idx = 2'(r);
      ext_d = {8'(r*16+3), 8'(r*16+2), 8'(r*16+1), 8'(r*16)};
      step("R2 row write");
    end
    idle(); rd_tr = 1'b1; rd_idx = 2'd2;
    #1;
    check("R4 column read fixed", rd0, 32'h32_22_12_02);
    step("R4 column read");
    rd_tr = 1'b0;
    #1;
    check("R3 row read fixed", rd0, 32'h23_22_21_20);
    step("R3 row read");

    // R5: transposed SRAM write to logical bank 1
    wr_src = 2'd2; wr_tr = 1'b1;
    for (int c = 0; c < DIM; c++) begin
      wr_en = 2'b10; wr_idx = 2'(c); sram_d = {8'(c+48), 8'(c+32), 8'(c+16), 8'(c+160)};
      step("R5 column write");
    end
    idle(); wr_tr = 1'b0; rd_tr = 1'b0; rd_idx = 2'd1;
    #1;
    check("R5 row after column write", rd1, 32'h13_12_11_10);
    read_all("R5 readback");

    // R6/R9: filter source, both banks in one cycle
    wr_src = 2'd1; wr_en = 2'b11; wr_idx = 2'd3; wr_tr = 1'b0;
    flt0_d = 32'hA0A1A2A3; flt1_d = 32'hB0B1B2B3;
    step("R9 dual write");
    idle(); rd_idx = 2'd3; rd_tr = 1'b0;
    #1;
    check("R6 filter to bank0", rd0, 32'hA0A1A2A3);
    check("R9 filter to bank1", rd1, 32'hB0B1B2B3);
    step("R9 after dual write");

    // R6: source 3 writes nothing
    wr_src = 2'd3; wr_en = 2'b11; ext_d = '1; sram_d = '1; flt0_d = '1; flt1_d = '1;
    step("R6 none source");
    read_all("R6 none source unchanged");

    // R8: read during write returns old, new next cycle
    wr_src = 2'd0; wr_en = 2'b01; wr_idx = 2'd0; wr_tr = 1'b0; ext_d = 32'h11223344;
    rd_idx = 2'd0; rd_tr = 1'b0;
    step("R8 read during write old data");
    idle();
    #1;
    check("R8 new data next cycle", rd0, 32'h11223344);
    step("R8 next cycle");

    // R7: swap, with write in the same cycle using the old mapping
    swap = 1'b1; wr_en = 2'b01; wr_idx = 2'd1; ext_d = 32'hCAFE0001;
    step("R7 swap with write");
    idle(); rd_idx = 2'd1; rd_tr = 1'b0;
    #1;
    check("R7 swapped role", rd1, 32'hCAFE0001);
    read_all("R7 after swap");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      wr_en  = 2'($urandom_range(0, 3));
      wr_src = 2'($urandom_range(0, 3));
      wr_idx = 2'($urandom_range(0, 3));
      wr_tr  = 1'($urandom_range(0, 1));
      swap   = ($urandom_range(0, 7) == 0);
      rd_idx = 2'($urandom_range(0, 3));
      rd_tr  = 1'($urandom_range(0, 1));
      ext_d = $urandom; flt0_d = $urandom; flt1_d = $urandom; sram_d = $urandom;
      step(rd_tr ? "R4 random" : "R3 random");
    end
    read_all("R7 random final");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule